// File: doc/BRIEF.md
# Single-Level Return Stack with Carry

This block keeps one saved return context for a small sequencer: a program counter of `PC_W` bits (13 by default) and a one-bit carry flag. A subroutine call or an interrupt entry writes the current return address into the entry. Only an interrupt entry also writes the carry flag. The caller supplies that return address already incremented. A second save simply replaces the first one. Nothing tracks depth or reports an overflow.

The saved address and the saved carry are always visible on the outputs. In the same cycle as a return request, the sequencer takes `ret_pc_o` as its next PC. On an interrupt return the block also raises `carry_load_o`, which tells the sequencer to take `ret_carry_o` into its carry flag. An ordinary return leaves the carry to the sequencer. Pops are read-only. A save and a pop in the same cycle give the old entry to the pop, and the new entry appears on the next cycle.

Top module: `rstk_single`

## Requirements
- R1: `ret_pc_o` and `ret_carry_o` always show the stored address and stored carry, combinationally from the entry register.
- R2: If `call_i` or `irq_i` is high at a rising clock edge, the stored address becomes `pc_i`. This is visible on `ret_pc_o` from the following cycle.
- R3: If `irq_i` is high at a rising clock edge, the stored carry becomes `carry_i`.
- R4: If `call_i` is high and `irq_i` is low at an edge, the stored carry keeps its previous value.
- R5: `carry_load_o` is high in exactly the cycles where `reti_i` is high. A cycle with only `ret_i` high leaves it low.
- R6: A save into an already occupied entry overwrites it. No error or other indication results.
- R7: If neither `call_i` nor `irq_i` is high at an edge, the entry is unchanged. This includes cycles with `ret_i` or `reti_i` high.
- R8: When a save and a pop fall in the same cycle, the outputs show the old entry during that cycle. The new entry is shown from the next cycle.
- R9: A rising edge with `rst_n` low clears the stored address to 0 and the stored carry to 0.
- R10: With `call_i` and `irq_i` both high, the save is treated as an interrupt entry, so the carry is captured as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | PC_W | Return address to save (already incremented) |
| carry_i | input | 1 | Current carry flag |
| call_i | input | 1 | Subroutine call: save address only |
| irq_i | input | 1 | Interrupt entry: save address and carry |
| ret_i | input | 1 | Ordinary return: pop address |
| reti_i | input | 1 | Interrupt return: pop address and carry |
| ret_pc_o | output | PC_W | Saved return address |
| ret_carry_o | output | 1 | Saved carry flag |
| carry_load_o | output | 1 | Sequencer must load `ret_carry_o` into its carry |

## Verification
Two of the block's functions can land in the same cycle: a save (call or interrupt) and a pop (return or interrupt return). The bench holds both strobes high across one edge, with a new address and carry on the inputs. It then checks that within that cycle the outputs still show the old address and carry, with `carry_load_o` matching the pop type, and that the next cycle shows the new entry. Simultaneous call and interrupt strobes are judged the same way, by whether the carry was captured.

// File: rtl/rstk_pkg.sv
// Package: shared sizes and the entry type for the single-level return stack.
// Assumes a program counter no wider than 32 bits.
package rstk_pkg;

    localparam int unsigned PC_W_DEF = 13;

    // Decoded per-cycle commands from the event strobes.
    typedef struct packed {
        logic save_pc;     // write the address field
        logic save_carry;  // write the carry field
        logic restore_c;   // pop asks for the carry back
    } rstk_cmd_t;

endpackage

// File: rtl/rstk_event_decode.sv
// Module: rstk_event_decode
// Turns the four event strobes into save and restore commands.
// An interrupt entry outranks a call, so a cycle with both saves the carry.
// Assumes the strobes are already synchronous to clk.
module rstk_event_decode
    import rstk_pkg::*;
(
    input  logic       call_i,
    input  logic       irq_i,
    input  logic       ret_i,
    input  logic       reti_i,
    output rstk_cmd_t  cmd_o
);

    logic pop_any;

    // Purpose: form the save and restore commands.
    always_comb begin
        cmd_o            = '0;
        cmd_o.save_pc    = call_i | irq_i;
        cmd_o.save_carry = irq_i;
        cmd_o.restore_c  = reti_i;
    end

    // Purpose: note whether a pop of any kind is requested (for the check below).
    always_comb pop_any = ret_i | reti_i;

    // R5: a plain return never asks for the carry.
    always_comb begin
        if (ret_i && !reti_i) begin
            a_plain_ret_no_carry_r5: assert (!cmd_o.restore_c && pop_any);
        end
    end

endmodule

// File: rtl/rstk_entry_reg.sv
// Module: rstk_entry_reg
// Holds the one saved return context: address and carry, written separately.
// Assumes a synchronous active-low reset that clears both fields.
module rstk_entry_reg #(
    parameter int unsigned PC_W = rstk_pkg::PC_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_pc,
    input  logic            we_carry,
    input  logic [PC_W-1:0] pc_d,
    input  logic            carry_d,
    output logic [PC_W-1:0] pc_q,
    output logic            carry_q
);

    // Purpose: address field; replaced on every save.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (we_pc) pc_q <= pc_d;
    end

    // Purpose: carry field; replaced only on interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n)        carry_q <= 1'b0;
        else if (we_carry) carry_q <= carry_d;
    end

    p_save_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_pc |=> pc_q == $past(pc_d));

    p_save_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_carry |=> carry_q == $past(carry_d));

    p_hold_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_pc && !we_carry) |=> $stable(carry_q));

    p_hold_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_pc |=> $stable(pc_q));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && !carry_q));

endmodule

// File: rtl/rstk_single.sv
// Module: rstk_single (top)
// One-entry return stack for a sequencer's PC plus carry flag.
// Saves on call or interrupt (carry only on interrupt). Pops are read-only:
// the stored entry is always on the outputs, and carry_load_o flags an
// interrupt return. Assumes the caller passes an already incremented address.
module rstk_single
    import rstk_pkg::*;
#(
    parameter int unsigned PC_W = PC_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc_i,
    input  logic            carry_i,
    input  logic            call_i,
    input  logic            irq_i,
    input  logic            ret_i,
    input  logic            reti_i,
    output logic [PC_W-1:0] ret_pc_o,
    output logic            ret_carry_o,
    output logic            carry_load_o
);

    rstk_cmd_t       cmd;
    logic [PC_W-1:0] pc_q;
    logic            carry_q;

    rstk_event_decode u_dec (
        .call_i (call_i),
        .irq_i  (irq_i),
        .ret_i  (ret_i),
        .reti_i (reti_i),
        .cmd_o  (cmd)
    );

    rstk_entry_reg #(.PC_W(PC_W)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_pc    (cmd.save_pc),
        .we_carry (cmd.save_carry),
        .pc_d     (pc_i),
        .carry_d  (carry_i),
        .pc_q     (pc_q),
        .carry_q  (carry_q)
    );

    // Purpose: expose the old entry to any pop in this cycle.
    always_comb begin
        ret_pc_o     = pc_q;
        ret_carry_o  = carry_q;
        carry_load_o = cmd.restore_c;
    end

    p_irq_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && irq_i) |=> ret_carry_o == $past(carry_i));

    p_pop_sees_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i || reti_i) && !call_i && !irq_i |=> $stable(ret_pc_o));

endmodule

// File: tb/tb_rstk_single.sv
// Directed bench for rstk_single: one task per scenario, each checking itself.
module tb_rstk_single;

    localparam int unsigned PC_W = 13;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] pc_i;
    logic            carry_i, call_i, irq_i, ret_i, reti_i;
    logic [PC_W-1:0] ret_pc_o;
    logic            ret_carry_o, carry_load_o;

    int checks = 0;
    int fails  = 0;

    logic [PC_W-1:0] m_pc;
    logic            m_c;

    always #2.5 clk = ~clk;  // 200 MHz

    rstk_single #(.PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .carry_i(carry_i),
        .call_i(call_i), .irq_i(irq_i), .ret_i(ret_i), .reti_i(reti_i),
        .ret_pc_o(ret_pc_o), .ret_carry_o(ret_carry_o), .carry_load_o(carry_load_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle's strobes after the falling edge; settle time before checking.
    task automatic drive(input logic c, input logic i, input logic r, input logic ri,
                         input logic [PC_W-1:0] pc, input logic cy);
        @(negedge clk);
        call_i = c; irq_i = i; ret_i = r; reti_i = ri; pc_i = pc; carry_i = cy;
        #0.5;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    // Check the outputs against the model (R1).
    task automatic chk_entry(input string req);
        chk({req, " pc"}, 32'(ret_pc_o), 32'(m_pc));
        chk({req, " carry"}, 32'(ret_carry_o), 32'(m_c));
    endtask

    task automatic t_reset();  // R9
        rst_n = 1'b0;
        idle(); idle();
        rst_n = 1'b1;
        m_pc = '0; m_c = 1'b0;
        chk_entry("R9 reset");
        chk("R5 no load at rest", 32'(carry_load_o), 0);
    endtask

    task automatic t_call();  // R2 R4
        drive(1'b1, 1'b0, 1'b0, 1'b0, 13'h0A5, 1'b1);
        m_pc = 13'h0A5;
        idle();
        chk_entry("R2/R4 call");
    endtask

    task automatic t_irq();  // R3
        drive(1'b0, 1'b1, 1'b0, 1'b0, 13'h1F00, 1'b1);
        m_pc = 13'h1F00; m_c = 1'b1;
        idle();
        chk_entry("R3 irq");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 13'h0003, 1'b0);
        m_pc = 13'h0003;
        idle();
        chk_entry("R4 call keeps carry");
    endtask

    task automatic t_overwrite();  // R6
        drive(1'b1, 1'b0, 1'b0, 1'b0, 13'h1111, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 13'h1FFF, 1'b0);
        m_pc = 13'h1FFF; m_c = 1'b0;
        idle();
        chk_entry("R6 overwrite");
    endtask

    task automatic t_pops();  // R5 R7
        drive(1'b0, 1'b0, 1'b1, 1'b0, 13'h0777, 1'b1);
        chk("R5 ret no load", 32'(carry_load_o), 0);
        chk_entry("R1 ret sees entry");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 13'h0777, 1'b1);
        chk("R5 reti load", 32'(carry_load_o), 1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 13'h0777, 1'b1);
        chk("R5 both load", 32'(carry_load_o), 1);
        idle();
        chk_entry("R7 pops leave entry");
    endtask

    task automatic t_same_cycle();  // R8
        drive(1'b0, 1'b1, 1'b0, 1'b1, 13'h0ABC, 1'b1);
        chk_entry("R8 old entry in save+pop cycle");
        chk("R8 reti load", 32'(carry_load_o), 1);
        m_pc = 13'h0ABC; m_c = 1'b1;
        idle();
        chk_entry("R8 new entry next cycle");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 13'h0042, 1'b0);
        chk_entry("R8 call+ret old entry");
        chk("R8 ret no load", 32'(carry_load_o), 0);
        m_pc = 13'h0042;
        idle();
        chk_entry("R8 call+ret new entry");
    endtask

    task automatic t_call_irq();  // R10
        drive(1'b1, 1'b1, 1'b0, 1'b0, 13'h0505, 1'b0);
        m_pc = 13'h0505; m_c = 1'b0;
        idle();
        chk_entry("R10 call+irq");
    endtask

    task automatic t_reset_mid();  // R9
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        m_pc = '0; m_c = 1'b0;
        chk_entry("R9 reset after use");
    endtask

    initial begin
        rst_n = 1'b0; pc_i = '0; carry_i = 1'b0;
        call_i = 1'b0; irq_i = 1'b0; ret_i = 1'b0; reti_i = 1'b0;
        t_reset();
        t_call();
        t_irq();
        t_overwrite();
        t_pops();
        t_same_cycle();
        t_call_irq();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule